// File: doc/BRIEF.md
# SPI Flash Host Controller

This block connects a system bus to one serial NOR flash device over a four-wire SPI link. It has two bus sides. The first is a small register port that selects the access style, the opcode, the address length and the write permission. The second is a flash window on which the bus issues reads and writes. The window stalls the bus until the serial transfer has finished, and it then returns a single-cycle ready pulse.

The block supports two ways of using the window.

- **Raw mode.** Software drives chip select through a control bit. Every window access moves one byte, or four bytes most significant first, and the window address plays no part. Software uses this mode to send flash commands, status requests, erases and streaming reads.
- **Direct modes (plain read, fast read and write).** Each word access becomes a complete flash transaction in its own chip-select frame. The frame carries the stored opcode, then the window offset as a 3-byte or 4-byte address, then (for fast read only) one byte of dummy clocks, then four data bytes.

The link always runs in SPI mode 0, with the serial clock derived from the system clock by a parameter.

Top module: `spi_host_ctl`

## Requirements
- R1: After reset:
  - register 0x00 reads 0x00000000;
  - register 0x04 reads 0x00000000;
  - register 0x10 reads 0x00030004 (plain read, opcode 0x03, 3-byte address, stop bit set);
  - `spi_cs_n` is high and `spi_sck` is low.
- R2: The three registers and their fields are as follows, and every other bit reads as 0:
  - register 0x00: bit 16 is the flash write permission;
  - register 0x04: bit 0 selects 4-byte addressing;
  - register 0x10: bits [1:0] are the mode (0 plain read, 1 fast read, 2 write, 3 raw), bit 2 is the chip-select stop bit, and bits [23:16] are the direct-mode opcode.
- R3: In raw mode `spi_cs_n` equals the stop bit. In the other modes `spi_cs_n` is high whenever no window access is in progress.
- R4: A raw byte write sends `win_wdata[7:0]` on `spi_mosi` most significant bit first, whatever the window address. The link uses mode 0: data is stable when `spi_sck` rises and changes when it falls.
- R5: A raw read sends 0x00 bytes. A byte read returns the received byte in bits [7:0], with the upper bits 0. A word read returns four received bytes, the first in bits [31:24].
- R6: A raw word write sends `win_wdata` as four bytes, starting with bits [31:24].
- R7: A plain direct read sends the opcode, then the address, then four 0x00 bytes. The word returned holds the first received data byte in bits [31:24].
- R8: With 4-byte addressing the address is the zero-extended window offset, sent as four bytes most significant first. With 3-byte addressing only offset bits [23:0] are sent, as three bytes.
- R9: A fast read sends one 0x00 dummy byte (8 clocks) between the address and the data bytes.
- R10: A direct write in write mode with write permission set sends the opcode, the address, then `win_wdata` as four bytes starting with bits [31:24].
- R11: These window accesses complete with a ready pulse, never assert chip select, and (for reads) return 0:
  - a write in write mode while write permission is clear;
  - a read in write mode;
  - a write in either read mode.
- R12: `win_ready` is high for exactly one cycle per access. Each direct access uses exactly one chip-select frame of its own.
- R13: `spi_sck` is low when idle, and it is low whenever chip select changes during direct-mode transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register port access strobe |
| reg_we | input | 1 | Register write when high, read when low |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| win_req | input | 1 | Window access request, held until `win_ready` |
| win_we | input | 1 | Window write when high |
| win_word | input | 1 | Word access when high, byte access when low (raw mode) |
| win_addr | input | WIN_AW (28) | Window offset, used as the flash address in direct modes |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Window read data, valid with `win_ready` |
| win_ready | output | 1 | Single-cycle access completion |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench targets the following corners and the failure each one exposes:

- **Address length.** It compares 3-byte and 4-byte addressing on offsets whose upper byte is non-zero. A design that ignores the length bit sends a frame one byte too long or too short, and the returned word slips by a byte.
- **Fast read.** A missing or doubled dummy byte shows up as a shifted read word and a wrong frame length.
- **Ignored accesses.** It issues writes in write mode with permission clear, plus cross-direction accesses in each direct mode. A design that lets them through opens a chip-select frame that the bench's frame counter catches.
- **Raw mode.** It streams bytes and words inside one software-held frame. Wrong byte order, a non-zero filler on reads, or chip select that does not follow the stop bit all change the captured bytes or the frame count.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

  typedef enum logic [1:0] {
    XM_READ  = 2'd0,
    XM_FAST  = 2'd1,
    XM_WRITE = 2'd2,
    XM_USER  = 2'd3
  } xfer_mode_e;

  localparam logic [7:0] OFS_CFG   = 8'h00;
  localparam logic [7:0] OFS_CSCTL = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h10;
  localparam int CFG_WEN_BIT   = 16;
  localparam int CTRL_STOP_BIT = 2;

  // Header bytes ahead of the data: opcode, address, optional dummy.
  function automatic logic [3:0] hdr_len(input xfer_mode_e m, input logic four);
    if (m == XM_USER) return 4'd0;
    return 4'd1 + (four ? 4'd4 : 4'd3) + ((m == XM_FAST) ? 4'd1 : 4'd0);
  endfunction

  // Byte j of a data phase of len bytes, most significant first.
  function automatic logic [7:0] data_byte(input logic [31:0] d, input logic [2:0] len,
                                           input logic [3:0] j);
    int sh;
    logic [31:0] t;
    sh = 8 * (int'(len) - 1 - int'(j));
    if (sh < 0) sh = 0;
    t = d >> sh;
    return t[7:0];
  endfunction

  // Byte number idx of the whole frame.
  function automatic logic [7:0] pick_byte(input logic [3:0] idx, input logic [3:0] hdr,
                                           input logic [7:0] op, input logic [31:0] a,
                                           input logic four, input logic [31:0] d,
                                           input logic [2:0] dlen);
    int na, k, sh;
    logic [31:0] t;
    if (idx >= hdr) return data_byte(d, dlen, idx - hdr);
    if (idx == 4'd0) return op;
    na = four ? 4 : 3;
    k  = int'(idx) - 1;
    if (k < na) begin
      sh = 8 * (na - 1 - k);
      t  = a >> sh;
      return t[7:0];
    end
    return 8'h00;
  endfunction

endpackage

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter logic [7:0] RST_OPCODE = 8'h03
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        wen,
  output logic        four,
  output xfer_mode_e  mode,
  output logic        stop,
  output logic [7:0]  opcode
);

  logic unused_wbits;
  assign unused_wbits = ^{wdata[31:24], wdata[15:3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen    <= 1'b0;
      four   <= 1'b0;
      mode   <= XM_READ;
      stop   <= 1'b1;
      opcode <= RST_OPCODE;
    end else if (sel && we) begin
      case (addr)
        OFS_CFG:   wen <= wdata[CFG_WEN_BIT];
        OFS_CSCTL: four <= wdata[0];
        OFS_CTRL: begin
          mode   <= xfer_mode_e'(wdata[1:0]);
          stop   <= wdata[CTRL_STOP_BIT];
          opcode <= wdata[23:16];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CFG:   rdata[CFG_WEN_BIT] = wen;
      OFS_CSCTL: rdata[0] = four;
      OFS_CTRL: begin
        rdata[1:0]           = mode;
        rdata[CTRL_STOP_BIT] = stop;
        rdata[23:16]         = opcode;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx
);

  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;
  logic [3:0]    ph;
  logic [7:0]    txs;

  assign mosi = busy & txs[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ph   <= '0;
      txs  <= '0;
      rx   <= '0;
      sck  <= 1'b0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          txs  <= tx;
          cnt  <= '0;
          ph   <= '0;
        end
      end else if (cnt == CNT_TOP) begin
        cnt <= '0;
        ph  <= ph + 4'd1;
        if (!ph[0]) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          txs <= {txs[6:0], 1'b0};
          if (ph == 4'd15) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);  // R13
  AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !sck));  // R13

endmodule

// File: rtl/spi_host_seq.sv
module spi_host_seq
  import spi_host_pkg::*;
#(
  parameter int WIN_AW = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_req,
  input  logic              win_we,
  input  logic              win_word,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [31:0]       win_wdata,
  input  xfer_mode_e        mode,
  input  logic [7:0]        opcode,
  input  logic              four,
  input  logic              wen,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  output logic              frame_on,
  output logic              win_ready,
  output logic [31:0]       win_rdata,
  output logic              seq_idle
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_st_e;

  seq_st_e     st;
  logic [3:0]  idx, hdr_q, last_idx;
  logic [2:0]  dlen_q;
  logic [31:0] addr_q, data_q;
  logic [7:0]  op_q;
  logic        four_q, launch, acc_ignore;

  // R10 R11: direction must match the mode, and write mode needs permission
  always_comb begin
    acc_ignore = 1'b0;
    if ((mode == XM_READ || mode == XM_FAST) && win_we) acc_ignore = 1'b1;
    if (mode == XM_WRITE && (!win_we || !wen))          acc_ignore = 1'b1;
  end

  assign last_idx  = hdr_q + 4'(dlen_q) - 4'd1;
  assign sh_start  = (st == S_RUN) && launch;
  assign sh_tx     = pick_byte(idx, hdr_q, op_q, addr_q, four_q, data_q, dlen_q);
  assign win_ready = (st == S_FIN);
  assign seq_idle  = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      hdr_q     <= '0;
      dlen_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      op_q      <= '0;
      four_q    <= 1'b0;
      launch    <= 1'b0;
      frame_on  <= 1'b0;
      win_rdata <= '0;
    end else begin
      if (sh_start) launch <= 1'b0;
      case (st)
        S_IDLE: if (win_req) begin
          win_rdata <= '0;
          hdr_q     <= hdr_len(mode, four);
          dlen_q    <= (mode == XM_USER && !win_word) ? 3'd1 : 3'd4;
          addr_q    <= 32'(win_addr);
          data_q    <= win_we ? win_wdata : 32'h0;
          op_q      <= opcode;
          four_q    <= four;
          idx       <= '0;
          if (acc_ignore) begin
            st <= S_FIN;
          end else begin
            st       <= S_RUN;
            launch   <= 1'b1;
            frame_on <= (mode != XM_USER);
          end
        end
        S_RUN: if (sh_done) begin
          if (idx >= hdr_q) win_rdata <= {win_rdata[23:0], sh_rx};
          if (idx == last_idx) begin
            st       <= S_FIN;
            frame_on <= 1'b0;
          end else begin
            idx    <= idx + 4'd1;
            launch <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |=> !win_ready);  // R12
  AST_FRAME_ENDS_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    win_ready |-> !frame_on);  // R12

endmodule

// File: rtl/spi_host_ctl.sv
module spi_host_ctl
  import spi_host_pkg::*;
#(
  parameter int         CLK_DIV    = 2,
  parameter int         WIN_AW     = 28,
  parameter logic [7:0] RST_OPCODE = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              win_req,
  input  logic              win_we,
  input  logic              win_word,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [31:0]       win_wdata,
  output logic [31:0]       win_rdata,
  output logic              win_ready,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  xfer_mode_e mode;
  logic       wen, four, stop, frame_on, seq_idle;
  logic [7:0] opcode, sh_tx, sh_rx;
  logic       sh_start, sh_busy, sh_done;

  spi_host_regs #(.RST_OPCODE(RST_OPCODE)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .wen(wen), .four(four),
    .mode(mode), .stop(stop), .opcode(opcode)
  );

  spi_host_seq #(.WIN_AW(WIN_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .win_req(win_req), .win_we(win_we),
    .win_word(win_word), .win_addr(win_addr), .win_wdata(win_wdata),
    .mode(mode), .opcode(opcode), .four(four), .wen(wen),
    .sh_done(sh_done), .sh_rx(sh_rx), .sh_start(sh_start), .sh_tx(sh_tx),
    .frame_on(frame_on), .win_ready(win_ready), .win_rdata(win_rdata),
    .seq_idle(seq_idle)
  );

  spi_host_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .busy(sh_busy), .done(sh_done), .rx(sh_rx)
  );

  // R3: raw mode follows the stop bit, direct modes frame each access
  assign spi_cs_n = (mode == XM_USER) ? stop : ~frame_on;

  AST_DIRECT_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != XM_USER && seq_idle) |-> spi_cs_n);  // R3
  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && win_req && win_we && mode == XM_WRITE && !wen) |=> (spi_cs_n && win_ready));  // R11
  AST_CS_EDGE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != XM_USER && ($rose(spi_cs_n) || $fell(spi_cs_n))) |-> !spi_sck);  // R13
  AST_NO_SHIFT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> !sh_busy);  // R12

endmodule

// File: tb/spi_host_ctl_bench.sv
`timescale 1ns/1ps
module spi_host_ctl_bench;

  localparam int AW = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        win_req = 0, win_we = 0, win_word = 0;
  logic [AW-1:0] win_addr = 0;
  logic [31:0] win_wdata = 0, win_rdata;
  logic        win_ready, spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  spi_host_ctl #(.CLK_DIV(2), .WIN_AW(AW), .RST_OPCODE(8'h03)) u_spi_host_ctl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .win_req(win_req), .win_we(win_we), .win_word(win_word),
    .win_addr(win_addr), .win_wdata(win_wdata), .win_rdata(win_rdata),
    .win_ready(win_ready), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- flash model: captures bytes, answers a fixed pattern
  function automatic logic [7:0] resp(input int k);
    return 8'((k * 37 + 92) & 255) ^ 8'hC3;
  endfunction

  int fr_cnt = 0, nlog = 0, bitn = 0, bk = 0;
  logic pc = 1'b1, ps = 1'b0;
  logic [7:0] sh_in = 0, rtmp;
  logic [7:0] blog [0:255];

  always @(spi_cs_n or spi_sck) begin
    if (pc && !spi_cs_n) begin
      fr_cnt++; bitn = 0; bk = 0;
      rtmp = resp(0); spi_miso = rtmp[7];
    end else if (!spi_cs_n && !ps && spi_sck) begin
      sh_in = {sh_in[6:0], spi_mosi};
      bitn++;
      if (bitn == 8) begin
        blog[nlog % 256] = sh_in; nlog++; bitn = 0; bk++;
      end
    end else if (!spi_cs_n && ps && !spi_sck) begin
      rtmp = resp(bk); spi_miso = rtmp[7 - bitn];
    end
    pc = spi_cs_n; ps = spi_sck;
  end

  // ---------------- helpers
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 0; reg_we = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_sel = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic win(input logic we, input logic word, input logic [AW-1:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    int t;
    @(negedge clk);
    win_req = 1; win_we = we; win_word = word; win_addr = a; win_wdata = d;
    t = 0;
    do begin @(negedge clk); t++; end while (!win_ready && t < 4000);
    if (!win_ready) chk("R12 access timeout", 0, 1);
    q = win_rdata;
    win_req = 0;
    @(negedge clk);
    chk("R12 ready single cycle", {31'b0, win_ready}, 0);
  endtask

  function automatic logic [7:0] ex_byte(input int k, input logic [7:0] op,
      input logic [31:0] a, input logic four, input logic fast,
      input logic [31:0] wd, input logic wr);
    int na, h;
    na = four ? 4 : 3;
    h  = 1 + na + (fast ? 1 : 0);
    if (k == 0) return op;
    if (k <= na) return 8'(a >> (8 * (na - k)));
    if (k < h) return 8'h00;
    return wr ? 8'(wd >> (8 * (3 - (k - h)))) : 8'h00;
  endfunction

  // ---------------- watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  // ---------------- main sequence
  initial begin
    logic [31:0] q, d;
    int base, f0, uk;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    reg_rd(8'h00, d); chk("R1 cfg reset", d, 32'h0);
    reg_rd(8'h04, d); chk("R1 csctl reset", d, 32'h0);
    reg_rd(8'h10, d); chk("R1 ctrl reset", d, 32'h0003_0004);
    chk("R1 cs idle", {31'b0, spi_cs_n}, 1);
    chk("R1 sck idle", {31'b0, spi_sck}, 0);

    // R2 field layout, unused bits read zero
    reg_wr(8'h00, 32'hFFFF_FFFF); reg_rd(8'h00, d); chk("R2 cfg bits", d, 32'h0001_0000);
    reg_wr(8'h04, 32'hFFFF_FFFF); reg_rd(8'h04, d); chk("R2 csctl bits", d, 32'h1);
    reg_wr(8'h10, 32'hFF5A_FFF8); reg_rd(8'h10, d); chk("R2 ctrl bits", d, 32'h005A_0000);
    reg_wr(8'h00, 0); reg_wr(8'h04, 0);

    // R3..R6 raw mode inside one software frame
    f0 = fr_cnt;
    reg_wr(8'h10, 32'h0003_0007);
    chk("R3 raw stop high", {31'b0, spi_cs_n}, 1);
    reg_wr(8'h10, 32'h0003_0003);
    chk("R3 raw stop low", {31'b0, spi_cs_n}, 0);
    uk = 0;
    base = nlog;
    win(1, 0, 28'h0ABCDE1, 32'hDEAD_BE9F, q);
    chk("R4 raw byte sent", {24'b0, blog[base % 256]}, 32'h9F); uk++;
    for (int i = 0; i < 3; i++) begin
      win(0, 0, AW'($urandom), $urandom, q);
      chk("R5 raw byte read", q, {24'b0, resp(uk)}); uk++;
    end
    base = nlog;
    win(1, 1, 28'h0000123, 32'h1234_5678, q);
    for (int k = 0; k < 4; k++)
      chk("R6 raw word byte", {24'b0, blog[(base + k) % 256]}, {24'b0, ex_byte(4 + k, 0, 0, 0, 0, 32'h1234_5678, 1)});
    uk += 4;
    base = nlog;
    win(0, 1, 28'h0000040, 32'hFFFF_FFFF, q);
    chk("R5 raw word read", q, {resp(uk), resp(uk + 1), resp(uk + 2), resp(uk + 3)});
    for (int k = 0; k < 4; k++)
      chk("R5 raw read filler", {24'b0, blog[(base + k) % 256]}, 0);
    reg_wr(8'h10, 32'h0003_0007);
    chk("R3 raw stop ends frame", {31'b0, spi_cs_n}, 1);
    chk("R3 one raw frame", fr_cnt - f0, 1);

    // Random direct accesses plus directed address corners
    for (int it = 0; it < 28; it++) begin
      int kind, na, h;
      logic four;
      logic [7:0] op;
      logic [AW-1:0] a;
      logic [31:0] wd;
      string tag;
      kind = $urandom_range(0, 2);
      four = 1'($urandom_range(0, 1));
      op   = 8'($urandom);
      a    = AW'($urandom);
      wd   = $urandom;
      if (it == 0) begin kind = 0; four = 1; a = 28'hFFF_FFFC; end
      if (it == 1) begin kind = 1; four = 0; a = 28'hABC_DEF0; end
      if (it == 2) begin kind = 2; four = 1; a = 28'h800_0001; end
      tag = (kind == 0) ? "R7" : (kind == 1) ? "R9" : "R10";
      reg_wr(8'h04, {31'b0, four});
      reg_wr(8'h00, (kind == 2) ? 32'h0001_0000 : 32'h0);
      reg_wr(8'h10, (32'(op) << 16) | 32'(kind));
      f0 = fr_cnt; base = nlog;
      win(kind == 2, 1, a, wd, q);
      na = four ? 4 : 3;
      h  = 1 + na + ((kind == 1) ? 1 : 0);
      chk({tag, " frame length"}, nlog - base, h + 4);
      for (int k = 0; k < h + 4; k++)
        chk((k >= 1 && k <= na) ? "R8 address byte" : tag,
            {24'b0, blog[(base + k) % 256]},
            {24'b0, ex_byte(k, op, 32'(a), four, kind == 1, wd, kind == 2)});
      if (kind != 2)
        chk({tag, " read word"}, q, {resp(h), resp(h + 1), resp(h + 2), resp(h + 3)});
      chk("R12 one frame per access", fr_cnt - f0, 1);
      chk("R13 cs released sck low", {30'b0, spi_cs_n, spi_sck}, 32'h2);
    end

    // R11 ignored accesses
    reg_wr(8'h00, 32'h0);
    reg_wr(8'h10, 32'h0002_0002);
    f0 = fr_cnt; base = nlog;
    win(1, 1, 28'h0001000, 32'hA5A5_A5A5, q);
    chk("R11 write without permission frames", fr_cnt - f0, 0);
    chk("R11 write without permission bytes", nlog - base, 0);
    reg_wr(8'h00, 32'h0001_0000);
    win(0, 1, 28'h0001000, 32'h0, q);
    chk("R11 read in write mode data", q, 0);
    chk("R11 read in write mode frames", fr_cnt - f0, 0);
    reg_wr(8'h10, 32'h0003_0000);
    win(1, 1, 28'h0002000, 32'h1111_2222, q);
    chk("R11 write in read mode frames", fr_cnt - f0, 0);
    reg_wr(8'h10, 32'h000B_0001);
    win(1, 1, 28'h0002000, 32'h1111_2222, q);
    chk("R11 write in fast mode frames", fr_cnt - f0, 0);

    // R12 back-to-back direct reads use separate frames
    reg_wr(8'h10, 32'h0003_0000);
    f0 = fr_cnt;
    win(0, 1, 28'h0000010, 0, q);
    win(0, 1, 28'h0000014, 0, q);
    chk("R12 two accesses two frames", fr_cnt - f0, 2);
    chk("R13 final idle", {30'b0, spi_cs_n, spi_sck}, 32'h2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule